// File: doc/BRIEF.md
# Buck Gate Sequencer with Adaptive Dead Time

This block turns a three-level PWM command into the two gate enables of a synchronous buck stage: `gh` for the high-side switch and `gl` for the low-side switch. It never lets both gates conduct. Each gate may turn on only after comparator feedback shows that the opposite switch has really turned off, and a short programmable dead time has then passed.

The falling edge of the PWM command has a second route to low-side turn-on. Once the high-side gate is sensed as discharged, a long timeout starts. When the timeout expires, the low side turns on even if the switch node never fell. This keeps the bootstrap capacitor recharged on every cycle.

A skip-mode input masks the low side cycle by cycle for diode emulation. A disable input holds both gates off, and so does an undriven-pin flag on that input. A hysteretic undervoltage lockout on a digitized driver-supply code also holds both gates off.

Top module: `buck_gate_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, `gh` and `gl` are 0. Lockout is engaged out of reset, so no gate turns on until the supply code first exceeds the release threshold.
- R2: Lockout releases when `vdrv_code` (50 mV per LSB) is above ON_CODE (default 146, about 7.3 V). It re-engages when the code is below OFF_CODE (default 139, about 6.95 V). Between the two thresholds the lockout keeps its previous state. Once lockout is engaged, both gates are 0 after the second rising edge that sampled a code below OFF_CODE.
- R3: If `dis_n` is 0 or `dis_open` is 1 when a rising edge samples it, both gates are 0 after that edge, whatever the PWM command.
- R4: `pwm_cmd` is encoded as follows: 2'b00 means low, 2'b01 means high, and 2'b10 or 2'b11 means off. An off command sampled at a rising edge makes both gates 0 after that edge.
- R5: A high command makes `gl` 0 at the next edge. `gh` becomes 1 at the DT_ON_CYC-th consecutive edge (default 2) that samples `lsg_low`=1 after the wait began.
- R6: A low command makes `gh` 0 at the next edge. `gl` becomes 1 at the DT_OFF_CYC-th consecutive edge (default 3) that samples `sw_low`=1.
- R7: In the low-side wait, the first edge that samples `hsg_low`=1 starts a timeout. The timeout keeps running even if `hsg_low` drops again. At its TMO_CYC-th edge (default 50), `gl` becomes 1 whatever the value of `sw_low`. Without either feedback, `gl` stays 0.
- R8: If the switch-node path completes before the timeout, `gl` turns on at the switch-node dead time. TMO_CYC must be larger than DT_OFF_CYC.
- R9: `skip_n`=0 sampled at an edge makes `gl` 0 after that edge without cancelling the low phase. When `skip_n` returns to 1 during a low command, `gl` is 1 after the next edge.
- R10: `gh` and `gl` are never 1 in the same cycle.
- R11: After a disable or a lockout ends, both gates start from 0. The first command then passes through the normal feedback-gated sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 2 | PWM command: 00 low, 01 high, 1x off |
| skip_n | input | 1 | Active-low skip mode; masks the low-side gate |
| dis_n | input | 1 | Active-low disable |
| dis_open | input | 1 | Disable pin sensed as undriven; treated as disabled |
| vdrv_code | input | VDRV_W | Digitized driver supply, 50 mV per LSB |
| lsg_low | input | 1 | Low-side gate sensed below turn-off threshold |
| sw_low | input | 1 | Switch node sensed below threshold |
| hsg_low | input | 1 | High-side gate sensed below discharge threshold |
| gh | output | 1 | High-side gate enable |
| gl | output | 1 | Low-side gate enable |

## Verification
The switch-node dead-time path and the fallback timeout can both be ready to turn on the low side in the same window. The bench arms the timeout with `hsg_low` and then raises `sw_low` well before the timeout can expire. The check requires `gl` to rise exactly at the switch-node dead time, once, and then stay on. A second case lets only the timeout run, with `hsg_low` held for a single cycle, and requires `gl` to rise exactly at the TMO_CYC-th edge.

// File: rtl/gsq_pkg.sv
package gsq_pkg;

  // Two-bit PWM command; bit 1 set means off.
  typedef enum logic [1:0] {
    PWM_LOW     = 2'b00,
    PWM_HIGH    = 2'b01,
    PWM_OFF     = 2'b10,
    PWM_OFF_ALT = 2'b11
  } pwm_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HI_WAIT = 3'd1,
    ST_HI_ON   = 3'd2,
    ST_LO_WAIT = 3'd3,
    ST_LO_ON   = 3'd4
  } seq_state_e;

  function automatic logic cmd_is_off(input logic [1:0] c);
    return c[1];
  endfunction

  function automatic logic cmd_is_high(input logic [1:0] c);
    return c == PWM_HIGH;
  endfunction

  function automatic logic cmd_is_low(input logic [1:0] c);
    return c == PWM_LOW;
  endfunction

endpackage

// File: rtl/gsq_uvlo.sv
// Hysteretic undervoltage lockout on a digitized supply code.
module gsq_uvlo #(
  parameter int VW       = 9,
  parameter int ON_CODE  = 146,
  parameter int OFF_CODE = 139
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] code,
  output logic          locked
);

  localparam logic [VW-1:0] ON_TH  = VW'(ON_CODE);
  localparam logic [VW-1:0] OFF_TH = VW'(OFF_CODE);

  logic locked_q;
  logic locked_d;
  logic locked_en;

  always_comb begin
    locked_d  = locked_q;
    locked_en = 1'b0;
    if (locked_q && (code > ON_TH)) begin
      locked_d  = 1'b0;
      locked_en = 1'b1;
    end else if (!locked_q && (code < OFF_TH)) begin
      locked_d  = 1'b1;
      locked_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
    end else if (locked_en) begin
      locked_q <= locked_d;
    end
  end

  assign locked = locked_q;

endmodule

// File: rtl/gsq_delay.sv
// Cycle counter: done pulses on the LIMIT-th counted edge.
// STICKY=1 keeps counting once started, until cleared.
module gsq_delay #(
  parameter int LIMIT  = 2,
  parameter bit STICKY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          step;

  generate
    if (STICKY) begin : g_sticky
      assign step = inc || (cnt_q != '0);
    end else begin : g_plain
      assign step = inc;
    end
  endgenerate

  assign done = step && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr || done) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (step) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/gsq_fsm.sv
// Break-before-make sequencer for the two gates.
module gsq_fsm
  import gsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] pwm_cmd,
  input  logic       skip_n,
  input  logic       lsg_low,
  input  logic       sw_low,
  input  logic       hsg_low,
  input  logic       on_done,
  input  logic       off_done,
  input  logic       tmo_done,
  output logic       on_inc,
  output logic       on_clr,
  output logic       off_inc,
  output logic       off_clr,
  output logic       tmo_inc,
  output logic       tmo_clr,
  output logic       gh,
  output logic       gl
);

  seq_state_e state_q, state_d;
  logic       gh_q, gh_d;
  logic       gl_q, gl_d;

  logic in_hi_wait;
  logic in_lo_wait;

  assign in_hi_wait = (state_q == ST_HI_WAIT);
  assign in_lo_wait = (state_q == ST_LO_WAIT);

  // Dead-time counters count consecutive feedback cycles.
  assign on_inc  = in_hi_wait && lsg_low;
  assign on_clr  = !(in_hi_wait && lsg_low);
  assign off_inc = in_lo_wait && sw_low;
  assign off_clr = !(in_lo_wait && sw_low);
  // Timeout counter latches itself once started.
  assign tmo_inc = in_lo_wait && hsg_low;
  assign tmo_clr = !in_lo_wait;

  always_comb begin
    state_d = state_q;
    if (!enable || cmd_is_off(pwm_cmd)) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_is_high(pwm_cmd))     state_d = ST_HI_WAIT;
          else if (cmd_is_low(pwm_cmd)) state_d = ST_LO_WAIT;
        end
        ST_HI_WAIT: begin
          if (cmd_is_low(pwm_cmd))  state_d = ST_LO_WAIT;
          else if (on_done)         state_d = ST_HI_ON;
        end
        ST_HI_ON: begin
          if (cmd_is_low(pwm_cmd))  state_d = ST_LO_WAIT;
        end
        ST_LO_WAIT: begin
          if (cmd_is_high(pwm_cmd))        state_d = ST_HI_WAIT;
          else if (off_done || tmo_done)   state_d = ST_LO_ON;
        end
        ST_LO_ON: begin
          if (cmd_is_high(pwm_cmd)) state_d = ST_HI_WAIT;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    gh_d = (state_d == ST_HI_ON);
    gl_d = (state_d == ST_LO_ON) && skip_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gh_q    <= 1'b0;
      gl_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      gh_q    <= gh_d;
      gl_q    <= gl_d;
    end
  end

  assign gh = gh_q;
  assign gl = gl_q;

endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer
  import gsq_pkg::*;
#(
  parameter int VDRV_W        = 9,
  parameter int UVLO_ON_CODE  = 146,
  parameter int UVLO_OFF_CODE = 139,
  parameter int DT_ON_CYC     = 2,
  parameter int DT_OFF_CYC    = 3,
  parameter int TMO_CYC       = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pwm_cmd,
  input  logic              skip_n,
  input  logic              dis_n,
  input  logic              dis_open,
  input  logic [VDRV_W-1:0] vdrv_code,
  input  logic              lsg_low,
  input  logic              sw_low,
  input  logic              hsg_low,
  output logic              gh,
  output logic              gl
);

  generate
    if (TMO_CYC <= DT_OFF_CYC) begin : g_bad_tmo
      $error("TMO_CYC must exceed DT_OFF_CYC");
    end
  endgenerate

  logic locked;
  logic enable;
  logic on_inc, on_clr, on_done;
  logic off_inc, off_clr, off_done;
  logic tmo_inc, tmo_clr, tmo_done;

  assign enable = !locked && dis_n && !dis_open;

  gsq_uvlo #(
    .VW       (VDRV_W),
    .ON_CODE  (UVLO_ON_CODE),
    .OFF_CODE (UVLO_OFF_CODE)
  ) u_uvlo (
    .clk    (clk),
    .rst_n  (rst_n),
    .code   (vdrv_code),
    .locked (locked)
  );

  gsq_delay #(.LIMIT(DT_ON_CYC), .STICKY(1'b0)) u_dt_on (
    .clk (clk), .rst_n (rst_n), .clr (on_clr), .inc (on_inc), .done (on_done)
  );

  gsq_delay #(.LIMIT(DT_OFF_CYC), .STICKY(1'b0)) u_dt_off (
    .clk (clk), .rst_n (rst_n), .clr (off_clr), .inc (off_inc), .done (off_done)
  );

  gsq_delay #(.LIMIT(TMO_CYC), .STICKY(1'b1)) u_tmo (
    .clk (clk), .rst_n (rst_n), .clr (tmo_clr), .inc (tmo_inc), .done (tmo_done)
  );

  gsq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .pwm_cmd  (pwm_cmd),
    .skip_n   (skip_n),
    .lsg_low  (lsg_low),
    .sw_low   (sw_low),
    .hsg_low  (hsg_low),
    .on_done  (on_done),
    .off_done (off_done),
    .tmo_done (tmo_done),
    .on_inc   (on_inc),
    .on_clr   (on_clr),
    .off_inc  (off_inc),
    .off_clr  (off_clr),
    .tmo_inc  (tmo_inc),
    .tmo_clr  (tmo_clr),
    .gh       (gh),
    .gl       (gl)
  );

endmodule

// File: rtl/gsq_checker.sv
module gsq_checker #(
  parameter int VW       = 9,
  parameter int OFF_CODE = 139
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pwm_cmd,
  input logic          skip_n,
  input logic          dis_n,
  input logic          dis_open,
  input logic [VW-1:0] vdrv_code,
  input logic          lsg_low,
  input logic          gh,
  input logic          gl
);

  localparam logic [VW-1:0] OFF_TH = VW'(OFF_CODE);

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh && gl));

  // R3
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_n || dis_open) |=> (!gh && !gl));

  // R4
  off_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_cmd[1] |=> (!gh && !gl));

  // R9
  skip_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_n |=> !gl);

  // R5
  hs_needs_ls_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh) |-> $past(lsg_low));

  // R6
  ls_after_hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl) |-> $past(!gh));

  // R2
  uvlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vdrv_code < OFF_TH) |=> ##1 (!gh && !gl));

endmodule

bind buck_gate_sequencer gsq_checker #(
  .VW       (VDRV_W),
  .OFF_CODE (UVLO_OFF_CODE)
) u_gsq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_cmd   (pwm_cmd),
  .skip_n    (skip_n),
  .dis_n     (dis_n),
  .dis_open  (dis_open),
  .vdrv_code (vdrv_code),
  .lsg_low   (lsg_low),
  .gh        (gh),
  .gl        (gl)
);

// File: tb/tb_buck_gate_sequencer.sv
module tb_buck_gate_sequencer;

  localparam int VW      = 9;
  localparam int DT_ON   = 2;
  localparam int DT_OFF  = 3;
  localparam int TMO     = 50;
  localparam int HOLD    = 60;
  localparam int NVEC    = 12;

  logic          clk;
  logic          rst_n;
  logic [1:0]    pwm_cmd;
  logic          skip_n, dis_n, dis_open;
  logic [VW-1:0] vdrv_code;
  logic          lsg_low, sw_low, hsg_low;
  logic          gh, gl;

  int checks = 0;
  int errors = 0;
  int overlap = 0;
  bit finished = 0;

  buck_gate_sequencer #(
    .VDRV_W(VW), .UVLO_ON_CODE(146), .UVLO_OFF_CODE(139),
    .DT_ON_CYC(DT_ON), .DT_OFF_CYC(DT_OFF), .TMO_CYC(TMO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .skip_n(skip_n),
    .dis_n(dis_n), .dis_open(dis_open), .vdrv_code(vdrv_code),
    .lsg_low(lsg_low), .sw_low(sw_low), .hsg_low(hsg_low),
    .gh(gh), .gl(gl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && gh && gl) overlap++;

  // {cmd[1:0], skip_n, dis_n, lsg, sw, hsg, exp_gh, exp_gl}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b01_1_1_1_0_0_1_0,  // R5  high, low side seen off
    9'b00_1_1_0_1_1_0_1,  // R6  low, switch node falls
    9'b00_0_1_0_1_1_0_0,  // R9  skip masks GL
    9'b00_1_1_0_1_1_0_1,  // R9  skip released, GL back
    9'b01_1_1_0_0_0_0_0,  // R5  no low-side feedback: GH waits
    9'b01_1_1_1_0_0_1_0,  // R5  feedback arrives
    9'b00_1_1_0_0_1_0_1,  // R7  timeout turns GL on
    9'b10_1_1_1_1_1_0_0,  // R4  off
    9'b11_1_1_1_1_1_0_0,  // R4  off, alternate code
    9'b01_1_0_1_1_1_0_0,  // R3  disabled
    9'b01_1_1_1_0_0_1_0,  // R11 re-enabled, normal sequencing
    9'b00_1_1_0_0_0_0_0   // R7  no feedback at all: GL stays off
  };
  localparam int VREQ [NVEC] = '{5, 6, 9, 9, 5, 5, 7, 4, 4, 3, 11, 7};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic egh, input logic egl);
    checks++;
    if (gh !== egh || gl !== egl) begin
      errors++;
      $display("FAIL %s gh=%b gl=%b expected gh=%b gl=%b", tag, gh, gl, egh, egl);
    end
  endtask

  task automatic set_in(input logic [1:0] c, input logic sk, input logic ds,
                        input logic l, input logic s, input logic h);
    pwm_cmd = c; skip_n = sk; dis_n = ds; lsg_low = l; sw_low = s; hsg_low = h;
  endtask

  initial begin
    rst_n = 1'b0; dis_open = 1'b0; vdrv_code = 9'd145;
    set_in(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(3);
    chk("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    step(10);
    chk("R1 lockout out of reset", 1'b0, 1'b0);
    vdrv_code = 9'd147;
    step(10);
    chk("R2 release above on code", 1'b1, 1'b0);
    vdrv_code = 9'd140;
    step(10);
    chk("R2 hysteresis band keeps running", 1'b1, 1'b0);
    vdrv_code = 9'd138;
    step(1);
    chk("R2 one edge after low code", 1'b1, 1'b0);
    step(1);
    chk("R2 off at second edge", 1'b0, 1'b0);
    vdrv_code = 9'd160;
    step(5);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      set_in(VEC[i][8:7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      step(HOLD);
      chk($sformatf("R%0d vector %0d", VREQ[i], i), VEC[i][1], VEC[i][0]);
    end

    // R6 exact timing: from high phase
    set_in(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(10);
    chk("R5 setup high phase", 1'b1, 1'b0);
    set_in(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1);
    chk("R6 GH off first", 1'b0, 1'b0);
    sw_low = 1'b1;
    step(DT_OFF - 1);
    chk("R6 before dead time", 1'b0, 1'b0);
    step(1);
    chk("R6 at dead time", 1'b0, 1'b1);

    // R5 exact timing: from low phase
    set_in(2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1);
    chk("R5 GL off first", 1'b0, 1'b0);
    lsg_low = 1'b1;
    step(DT_ON - 1);
    chk("R5 before dead time", 1'b0, 1'b0);
    step(1);
    chk("R5 at dead time", 1'b1, 1'b0);

    // R7 exact: single-cycle hsg pulse starts the timeout
    set_in(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1);
    chk("R7 GH off", 1'b0, 1'b0);
    hsg_low = 1'b1;
    step(1);
    hsg_low = 1'b0;
    step(TMO - 2);
    chk("R7 before timeout", 1'b0, 1'b0);
    step(1);
    chk("R7 at timeout", 1'b0, 1'b1);

    // R8 both paths armed: switch node wins
    set_in(2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    step(10);
    set_in(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    step(10);
    chk("R8 timeout running, no GL yet", 1'b0, 1'b0);
    sw_low = 1'b1;
    step(DT_OFF - 1);
    chk("R8 before switch-node dead time", 1'b0, 1'b0);
    step(1);
    chk("R8 switch-node path first", 1'b0, 1'b1);
    step(TMO);
    chk("R8 GL stays on", 1'b0, 1'b1);

    // R9 exact
    skip_n = 1'b0;
    step(1);
    chk("R9 skip off next edge", 1'b0, 1'b0);
    skip_n = 1'b1;
    step(1);
    chk("R9 skip release next edge", 1'b0, 1'b1);

    // R3 open disable pin and R11 restart
    dis_open = 1'b1;
    step(1);
    chk("R3 open disable", 1'b0, 1'b0);
    set_in(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    dis_open = 1'b0;
    step(10);
    chk("R11 first low command waits for feedback", 1'b0, 1'b0);
    sw_low = 1'b1;
    step(DT_OFF - 1);
    chk("R11 before dead time", 1'b0, 1'b0);
    step(1);
    chk("R11 at dead time", 1'b0, 1'b1);

    // R4 exact
    pwm_cmd = 2'b10;
    step(1);
    chk("R4 off next edge", 1'b0, 1'b0);

    checks++;
    if (overlap != 0) begin
      errors++;
      $display("FAIL R10 overlap cycles=%0d expected=0", overlap);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule